// File: doc/BRIEF.md
# Port group mask forwarding resolver

This block decides which egress ports a frame leaves on in a small Ethernet switch. For every frame it reads three entries from a single shared table of port masks and forwards to the intersection of them. The first entry is the destination set: it is chosen by the MAC table result, or by a flood group picked from the frame class when the destination address is unknown. The second entry is an aggregation entry chosen by a 4-bit link aggregation code, so that each flow leaves on exactly one member of a bundled link. The third entry is a source entry chosen by the ingress port, which says which egress ports that ingress port may reach.

Each mask has one bit per physical port plus one bit for the CPU, placed directly above the physical ports. Lookups run in a two-stage pipeline that accepts one request per clock. A simple write/read port lets software load and inspect any table entry.

Top module: `fwd_resolver`

## Requirements
- R1: The egress set is the bitwise AND of the destination entry, the aggregation entry and the source entry. The result and res_valid appear two clocks after req_valid is sampled, and one request is accepted on every clock.
- R2: When req_hit is 1, the destination entry is the one at index req_dest_idx (0 to 63).
- R3: When req_hit is 0 and the destination address is all ones, the broadcast flood entry is used. Its index is 63 by default.
- R4: When req_hit is 0 and the address starts with 01:00:5E (group bit set), the IPv4 multicast flood entry is used (index 61). Any other address whose group bit (bit 40, the low bit of the first octet) is set, apart from those in R3 and R5, uses the non-IP multicast flood entry (index 60).
- R5: When req_hit is 0 and the address starts with 33:33, the IPv6 multicast flood entry is used (index 62).
- R6: When req_hit is 0 and the group bit is clear, the unknown unicast flood entry is used (index 59).
- R7: The aggregation entry sits at index 64 plus req_lag_code.
- R8: The source entry sits at index 80 plus req_src_port. A port whose own bit is cleared in its source entry does not forward to itself.
- R9: After reset, entries 0 to N-1 hold only their own bit p, entries 80 to 80+N-1 hold all ones (physical ports and CPU), and every other entry, including the discard entry 57, holds zero.
- R10: A cfg_rd returns the addressed entry on cfg_rdata one clock later. Indices above the last entry (90 by default) read as zero, and writes to them change no entry.
- R11: A write that lands on the same clock as a lookup of the same entry does not affect the frame being looked up on that clock. The next frame sees the new value.
- R12: The CPU bit sits at position N (bit 11 by default) in every mask. An entry holding only that bit (index 58 after configuration) sends a frame to the CPU alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Frame lookup request |
| req_src_port | input | 4 | Ingress port number |
| req_hit | input | 1 | MAC table hit |
| req_dest_idx | input | 6 | Destination entry index from the MAC table |
| req_dmac | input | 48 | Destination MAC address, first octet in bits 47:40 |
| req_lag_code | input | 4 | Link aggregation code |
| res_valid | output | 1 | Result valid |
| res_ports | output | 12 | Egress port set; bit 11 is the CPU |
| cfg_wr | input | 1 | Table write strobe |
| cfg_rd | input | 1 | Table read strobe |
| cfg_idx | input | 7 | Table entry index |
| cfg_wdata | input | 12 | Write data |
| cfg_rdata | output | 12 | Read data, valid the clock after cfg_rd |

## Verification
The bench loads distinct masks into each flood group, a multi-port group, one aggregation entry and one source entry. Each lookup can then only produce its expected set if the right entry was chosen. Frames are sent back to back in several forms: a hit, a broadcast address, an IPv4 group prefix, an IPv6 group prefix, a group address that is one bit away from the IPv4 prefix, and a plain unicast address. Together these separate all five frame classes and the hit path. Lookups through a narrow aggregation entry and through a source entry without its own port show that all three masks are ANDed. The bench also reads back the reset contents through the configuration port, tries an out-of-range write and read, and places a write on the same clock as a lookup to show that the new value only reaches the following frame.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [2:0] {
    FC_UCAST,
    FC_MCAST,
    FC_IP4MC,
    FC_IP6MC,
    FC_BCAST
  } fclass_e;

  // Frame class from the destination MAC; first octet is dmac[47:40].
  function automatic fclass_e classify(input logic [47:0] dmac);
    if (&dmac)                                   return FC_BCAST;
    else if (dmac[47:24] == 24'h01005E)          return FC_IP4MC;
    else if (dmac[47:32] == 16'h3333)            return FC_IP6MC;
    else if (dmac[40])                           return FC_MCAST;
    else                                         return FC_UCAST;
  endfunction

endpackage

// File: rtl/fwd_mask_table.sv
module fwd_mask_table #(
  parameter int NPORTS  = 11,
  parameter int MW      = NPORTS + 1,
  parameter int IW      = 7,
  parameter int ENTRIES = 80 + NPORTS,
  parameter int SRC_BASE = 80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [MW-1:0] wr_data,
  input  logic [IW-1:0] dst_idx,
  input  logic [IW-1:0] aggr_idx,
  input  logic [IW-1:0] src_idx,
  input  logic [IW-1:0] cfg_idx,
  output logic [MW-1:0] dst_mask,
  output logic [MW-1:0] aggr_mask,
  output logic [MW-1:0] src_mask,
  output logic [MW-1:0] cfg_mask
);

  logic [MW-1:0] tbl [ENTRIES];

  function automatic logic [MW-1:0] reset_value(input int idx);
    if (idx < NPORTS)                                  return MW'(1) << idx;
    else if (idx >= SRC_BASE && idx < SRC_BASE + NPORTS) return '1;
    else                                               return '0;
  endfunction

  function automatic logic in_range(input logic [IW-1:0] idx);
    return int'(idx) < ENTRIES;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= reset_value(i);
    end else if (wr_en && in_range(wr_idx)) begin
      tbl[wr_idx] <= wr_data;
    end
  end

  assign dst_mask  = in_range(dst_idx)  ? tbl[dst_idx]  : '0;
  assign aggr_mask = in_range(aggr_idx) ? tbl[aggr_idx] : '0;
  assign src_mask  = in_range(src_idx)  ? tbl[src_idx]  : '0;
  assign cfg_mask  = in_range(cfg_idx)  ? tbl[cfg_idx]  : '0;

endmodule

// File: rtl/fwd_dest_select.sv
module fwd_dest_select
  import fwd_pkg::*;
#(
  parameter int IW       = 7,
  parameter int FLOOD_UC = 59,
  parameter int FLOOD_MC = 60,
  parameter int FLOOD_V4 = 61,
  parameter int FLOOD_V6 = 62,
  parameter int FLOOD_BC = 63
) (
  input  logic          hit,
  input  logic [5:0]    hit_idx,
  input  logic [47:0]   dmac,
  output logic [IW-1:0] dst_idx
);

  fclass_e cls;

  always_comb begin
    cls = classify(dmac);
    if (hit) begin
      dst_idx = IW'(hit_idx);
    end else begin
      unique case (cls)
        FC_BCAST: dst_idx = IW'(FLOOD_BC);
        FC_IP4MC: dst_idx = IW'(FLOOD_V4);
        FC_IP6MC: dst_idx = IW'(FLOOD_V6);
        FC_MCAST: dst_idx = IW'(FLOOD_MC);
        default:  dst_idx = IW'(FLOOD_UC);
      endcase
    end
  end

endmodule

// File: rtl/fwd_resolver.sv
module fwd_resolver #(
  parameter int NPORTS   = 11,
  parameter int FLOOD_UC = 59,
  parameter int FLOOD_MC = 60,
  parameter int FLOOD_V4 = 61,
  parameter int FLOOD_V6 = 62,
  parameter int FLOOD_BC = 63,
  localparam int MW       = NPORTS + 1,
  localparam int PW       = $clog2(NPORTS),
  localparam int IW       = 7,
  localparam int AGGR_BASE = 64,
  localparam int SRC_BASE = 80,
  localparam int ENTRIES  = SRC_BASE + NPORTS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [PW-1:0] req_src_port,
  input  logic          req_hit,
  input  logic [5:0]    req_dest_idx,
  input  logic [47:0]   req_dmac,
  input  logic [3:0]    req_lag_code,
  output logic          res_valid,
  output logic [MW-1:0] res_ports,
  input  logic          cfg_wr,
  input  logic          cfg_rd,
  input  logic [IW-1:0] cfg_idx,
  input  logic [MW-1:0] cfg_wdata,
  output logic [MW-1:0] cfg_rdata
);

  // stage 1: resolved indices
  logic          s1_valid;
  logic [IW-1:0] s1_dst_idx, s1_aggr_idx, s1_src_idx;
  logic [IW-1:0] sel_dst_idx;

  // table read results for the frame in stage 2
  logic [MW-1:0] dst_mask, aggr_mask, src_mask, cfg_mask;

  fwd_dest_select #(
    .IW(IW), .FLOOD_UC(FLOOD_UC), .FLOOD_MC(FLOOD_MC),
    .FLOOD_V4(FLOOD_V4), .FLOOD_V6(FLOOD_V6), .FLOOD_BC(FLOOD_BC)
  ) u_dsel (
    .hit     (req_hit),
    .hit_idx (req_dest_idx),
    .dmac    (req_dmac),
    .dst_idx (sel_dst_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid    <= 1'b0;
      s1_dst_idx  <= '0;
      s1_aggr_idx <= '0;
      s1_src_idx  <= '0;
    end else begin
      s1_valid    <= req_valid;
      s1_dst_idx  <= sel_dst_idx;
      s1_aggr_idx <= IW'(AGGR_BASE) + IW'(req_lag_code);
      s1_src_idx  <= IW'(SRC_BASE) + IW'(req_src_port);
    end
  end

  fwd_mask_table #(
    .NPORTS(NPORTS), .MW(MW), .IW(IW), .ENTRIES(ENTRIES), .SRC_BASE(SRC_BASE)
  ) u_tbl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr),
    .wr_idx    (cfg_idx),
    .wr_data   (cfg_wdata),
    .dst_idx   (s1_dst_idx),
    .aggr_idx  (s1_aggr_idx),
    .src_idx   (s1_src_idx),
    .cfg_idx   (cfg_idx),
    .dst_mask  (dst_mask),
    .aggr_mask (aggr_mask),
    .src_mask  (src_mask),
    .cfg_mask  (cfg_mask)
  );

  // stage 2: combine the three masks
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_ports <= '0;
      cfg_rdata <= '0;
    end else begin
      res_valid <= s1_valid;
      res_ports <= s1_valid ? (dst_mask & aggr_mask & src_mask) : '0;
      if (cfg_rd) cfg_rdata <= cfg_mask;
    end
  end

endmodule

// File: rtl/fwd_resolver_chk.sv
module fwd_resolver_chk #(
  parameter int NPORTS = 11,
  localparam int MW = NPORTS + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_hit,
  input logic [5:0]    req_dest_idx,
  input logic [47:0]   req_dmac,
  input logic          s1_valid,
  input logic [6:0]    s1_dst_idx,
  input logic [MW-1:0] aggr_mask,
  input logic [MW-1:0] src_mask,
  input logic          res_valid,
  input logic [MW-1:0] res_ports,
  input logic          cfg_rd,
  input logic [6:0]    cfg_idx,
  input logic [MW-1:0] cfg_rdata
);

  // R1: request reaches stage 1, then the output
  p_req_to_s1_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> s1_valid);
  p_s1_to_res_r1: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> res_valid);
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !res_valid);

  // R7 / R8: result never exceeds the aggregation or source entry
  p_aggr_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> (res_ports & ~$past(aggr_mask)) == '0);
  p_src_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> (res_ports & ~$past(src_mask)) == '0);

  // R2: a hit carries its index
  p_hit_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_hit) |=> s1_dst_idx == 7'($past(req_dest_idx)));

  // R3: broadcast miss goes to the broadcast flood group
  p_bcast_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_hit && (&req_dmac)) |=> s1_dst_idx == 7'd63);

  // R6: unicast miss goes to the unicast flood group
  p_ucast_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_hit && !req_dmac[40]) |=> s1_dst_idx == 7'd59);

  // R10: out-of-range reads return zero
  p_cfg_oob_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && int'(cfg_idx) >= 80 + NPORTS) |=> cfg_rdata == '0);

endmodule

bind fwd_resolver fwd_resolver_chk #(.NPORTS(NPORTS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_hit      (req_hit),
  .req_dest_idx (req_dest_idx),
  .req_dmac     (req_dmac),
  .s1_valid     (s1_valid),
  .s1_dst_idx   (s1_dst_idx),
  .aggr_mask    (aggr_mask),
  .src_mask     (src_mask),
  .res_valid    (res_valid),
  .res_ports    (res_ports),
  .cfg_rd       (cfg_rd),
  .cfg_idx      (cfg_idx),
  .cfg_rdata    (cfg_rdata)
);

// File: tb/tb_fwd_resolver.sv
module tb_fwd_resolver;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_src_port = '0;
  logic        req_hit = 1'b0;
  logic [5:0]  req_dest_idx = '0;
  logic [47:0] req_dmac = '0;
  logic [3:0]  req_lag_code = '0;
  logic        res_valid;
  logic [11:0] res_ports;
  logic        cfg_wr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [6:0]  cfg_idx = '0;
  logic [11:0] cfg_wdata = '0;
  logic [11:0] cfg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fwd_resolver dut (.*);

  // {src 4, hit 1, idx 6, dmac 48, lag 4, expected 12}
  localparam logic [74:0] VEC [NV] = '{
    {4'd5, 1'b1, 6'd3,  48'h0000_0000_0000, 4'd0, 12'h008}, // R2 hit single port
    {4'd5, 1'b0, 6'd0,  48'hFFFF_FFFF_FFFF, 4'd0, 12'hFFF}, // R3 broadcast
    {4'd2, 1'b0, 6'd0,  48'hFFFF_FFFF_FFFF, 4'd0, 12'hFFB}, // R8 source excludes self
    {4'd5, 1'b0, 6'd0,  48'h0100_5E01_0203, 4'd0, 12'h0F0}, // R4 IPv4 group
    {4'd5, 1'b0, 6'd0,  48'h3333_0000_0001, 4'd0, 12'h300}, // R5 IPv6 group
    {4'd5, 1'b0, 6'd0,  48'h0102_0304_0506, 4'd0, 12'h80F}, // R4 non-IP group
    {4'd5, 1'b0, 6'd0,  48'h0001_0203_0405, 4'd0, 12'h0FF}, // R6 unicast
    {4'd5, 1'b0, 6'd0,  48'h0100_5F00_0001, 4'd0, 12'h80F}, // R4 prefix off by one
    {4'd5, 1'b1, 6'd20, 48'h0000_0000_0000, 4'd3, 12'h0C0}, // R7 aggregation narrows
    {4'd5, 1'b1, 6'd58, 48'h0000_0000_0000, 4'd0, 12'h800}, // R12 CPU only
    {4'd5, 1'b1, 6'd57, 48'h0000_0000_0000, 4'd0, 12'h000}, // R9 discard entry
    {4'd2, 1'b1, 6'd2,  48'h0000_0000_0000, 4'd0, 12'h000}, // R8 no hairpin
    {4'd5, 1'b0, 6'd0,  48'h0000_5E00_0001, 4'd0, 12'h0FF}, // R6 unicast with 5E
    {4'd5, 1'b1, 6'd63, 48'hFFFF_FFFF_FFFF, 4'd3, 12'h0F0}  // R1 AND of all three
  };

  task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cfg_write(input int idx, input logic [11:0] data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = 7'(idx); cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input int idx, output logic [11:0] data);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_idx = 7'(idx);
    @(negedge clk);
    cfg_rd = 1'b0;
    data = cfg_rdata;
  endtask

  task automatic drive(input logic [74:0] v);
    req_valid    = 1'b1;
    req_src_port = v[74:71];
    req_hit      = v[70];
    req_dest_idx = v[69:64];
    req_dmac     = v[63:16];
    req_lag_code = v[15:12];
  endtask

  initial begin
    logic [11:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset res_valid", {11'b0, res_valid}, 12'h000);

    // R9: reset contents read back
    cfg_read(0, rd);  check("R9 entry 0", rd, 12'h001);
    cfg_read(10, rd); check("R9 entry 10", rd, 12'h400);
    cfg_read(11, rd); check("R9 entry 11", rd, 12'h000);
    cfg_read(58, rd); check("R9 entry 58", rd, 12'h000);
    cfg_read(64, rd); check("R9 entry 64", rd, 12'h000);
    cfg_read(85, rd); check("R9 entry 85", rd, 12'hFFF);
    cfg_read(90, rd); check("R9 entry 90", rd, 12'hFFF);

    // R10: out-of-range index
    cfg_write(100, 12'h123);
    cfg_read(100, rd); check("R10 read beyond table", rd, 12'h000);
    cfg_read(90, rd);  check("R10 last entry untouched", rd, 12'hFFF);
    cfg_read(36, rd);  check("R10 aliased entry untouched", rd, 12'h000);

    // configuration
    for (int i = 64; i < 80; i++) cfg_write(i, 12'hFFF);
    cfg_write(67, 12'h0F0);
    cfg_write(58, 12'h800);
    cfg_write(59, 12'h0FF);
    cfg_write(60, 12'h80F);
    cfg_write(61, 12'h0F0);
    cfg_write(62, 12'h300);
    cfg_write(63, 12'hFFF);
    cfg_write(20, 12'h0C3);
    cfg_write(82, 12'hFFB);
    cfg_read(82, rd); check("R10 write read back", rd, 12'hFFB);

    // vector table, back to back
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check($sformatf("R1 valid vec %0d", i-2), {11'b0, res_valid}, 12'h001);
        check($sformatf("vec %0d", i-2), res_ports, VEC[i-2][11:0]);
      end
      if (i < NV) drive(VEC[i]);
      else req_valid = 1'b0;
    end
    @(negedge clk);
    check("R1 idle after burst", {11'b0, res_valid}, 12'h000);

    // R11: write on the lookup clock of the same entry
    drive({4'd5, 1'b0, 6'd0, 48'hFFFF_FFFF_FFFF, 4'd0, 12'h0});
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = 7'd63; cfg_wdata = 12'h00F;
    @(negedge clk);
    cfg_wr = 1'b0; req_valid = 1'b0;
    check("R11 frame in flight sees old", res_ports, 12'hFFF);
    @(negedge clk);
    check("R11 next frame sees new", res_ports, 12'h00F);
    @(negedge clk);
    check("R1 idle", {11'b0, res_valid}, 12'h000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule